// File: doc/BRIEF.md
# Burst Address Order Generator

This block produces the word address for each data phase of a burst on a parallel memory bus. At the start of a burst it captures the start address, a two-bit burst-order code, the programmed cache-line size and a flag that selects a 64-bit data path. After that, every completed data phase moves the address forward by one unit. A unit is one 32-bit word, or two words in 64-bit mode.

Three orders are supported. Linear order increments the address. Toggle order forms each word address as the start word XORed with a running phase offset. Wrap order starts at the critical word, walks through the cache line and wraps at its end. When the line is finished it moves to the same offset in the next line.

Some requests cannot be honoured: a reserved order code, a cache-line size the block does not support when toggle or wrap order is asked for, or a 64-bit start address that is not aligned to 8 bytes. For these the block raises a force-single-word flag, which tells the surrounding target logic to end the burst after the first word. The address then stays frozen at the start word.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `addr_o` is 0 and `single_o` is 0.
- R2: On the cycle after `start_i` is high, `addr_o` equals `start_addr_i` with bits [1:0] cleared.
- R3: When neither `start_i` nor `phase_done_i` was high on the previous cycle, `addr_o` does not change.
- R4: Linear order (`order_i` = 2'b00) adds 4 to `addr_o` for each completed phase, or 8 when `wide_i` was high at start.
- R5: Toggle order (`order_i` = 2'b01) gives word address S XOR T after the phases completed so far. S is the start word address (`start_addr_i[31:2]`) and T is the number of completed phases times the unit (1 word, or 2 in 64-bit mode).
- R6: Wrap order (`order_i` = 2'b10) with line size L words keeps the word address inside the aligned L-word line. The offset within the line is (S mod L + T) mod L.
- R7: In wrap order, once T reaches a multiple of L, the address sits in the line T words above the start line, at the start offset S mod L.
- R8: The reserved order code 2'b11 sets `single_o` on the cycle after start.
- R9: For toggle and wrap order, a line size other than 4, 8, 16 or 32 words (0 included) sets `single_o`. For linear order the line size has no effect.
- R10: With `wide_i` high, a start address with bit 2 set sets `single_o`.
- R11: While `single_o` is high, `phase_done_i` strobes leave `addr_o` unchanged.
- R12: When `start_i` and `phase_done_i` are high in the same cycle, the start wins. The next `addr_o` is the new start address and the phase count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | New burst: capture the settings below |
| start_addr_i | input | 32 | Byte start address of the burst |
| order_i | input | 2 | Burst order: 00 linear, 01 toggle, 10 wrap, 11 reserved |
| line_words_i | input | 8 | Cache-line size in 32-bit words |
| wide_i | input | 1 | 64-bit data path: two words per phase |
| phase_done_i | input | 1 | Strobe: one data phase completed |
| addr_o | output | 32 | Byte address of the current data phase |
| single_o | output | 1 | Burst must end after the first word |

## Verification
A wrong phase count or a wrong captured setting shows up on `addr_o` at the first completed phase after start. Each phase step is checked on the very next cycle, so a fault reports within one phase. Wrap bugs appear only at a line boundary and at the move into the next line, so wrap bursts are run past two full lines for every legal line size, in both widths. A stale or missing `single_o` shows the cycle after start, and again as an address that moves when it must stay frozen.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [1:0] {
        ORD_LINEAR = 2'b00,
        ORD_TOGGLE = 2'b01,
        ORD_WRAP   = 2'b10,
        ORD_RSVD   = 2'b11
    } order_e;
endpackage

// File: rtl/burst_order_check.sv
module burst_order_check
    import burst_seq_pkg::*;
#(
    parameter int LW      = 8,
    parameter int WW      = 30,
    parameter int MIN_LOG = 2,
    parameter int MAX_LOG = 5
) (
    input  logic [1:0]    order_i,
    input  logic [LW-1:0] line_i,
    input  logic          wide_i,
    input  logic          word_bit0_i,
    output logic          single_o,
    output logic [WW-1:0] mask_o
);
    localparam int NSZ = MAX_LOG - MIN_LOG + 1;

    logic [NSZ-1:0] size_hit;

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        assign size_hit[g] = (line_i == LW'(1 << (g + MIN_LOG)));
    end

    logic line_ok;
    logic needs_line;

    always_comb begin
        line_ok    = |size_hit;
        needs_line = (order_i == ORD_TOGGLE) || (order_i == ORD_WRAP);
        single_o   = (order_i == ORD_RSVD)
                   || (needs_line && !line_ok)
                   || (wide_i && word_bit0_i);
        mask_o     = WW'(line_i) - WW'(1);
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc
    import burst_seq_pkg::*;
#(
    parameter int WW = 30
) (
    input  logic [1:0]    order_i,
    input  logic [WW-1:0] start_word_i,
    input  logic [WW-1:0] total_i,
    input  logic [WW-1:0] mask_i,
    output logic [WW-1:0] word_o
);
    logic [WW-1:0] in_line;
    logic [WW-1:0] line_base;

    always_comb begin
        in_line   = ((start_word_i & mask_i) + (total_i & mask_i)) & mask_i;
        line_base = (start_word_i & ~mask_i) + (total_i & ~mask_i);
        case (order_i)
            ORD_TOGGLE: word_o = start_word_i ^ total_i;
            ORD_WRAP:   word_o = line_base | in_line;
            default:    word_o = start_word_i + total_i;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LW      = 8,
    parameter int MIN_LOG = 2,
    parameter int MAX_LOG = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic [1:0]    order_i,
    input  logic [LW-1:0] line_words_i,
    input  logic          wide_i,
    input  logic          phase_done_i,
    output logic [AW-1:0] addr_o,
    output logic          single_o
);
    localparam int WW = AW - 2;

    typedef struct packed {
        logic [WW-1:0] start_word;
        logic [1:0]    order;
        logic [WW-1:0] mask;
        logic          wide;
        logic          single;
        logic [WW-1:0] total;
        logic [WW-1:0] word;
    } seq_t;

    seq_t st_d, st_q;

    logic          chk_single;
    logic [WW-1:0] chk_mask;
    logic [WW-1:0] calc_word;
    logic [WW-1:0] unit;
    logic [WW-1:0] total_next;

    burst_order_check #(
        .LW(LW), .WW(WW), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)
    ) u_check (
        .order_i     (order_i),
        .line_i      (line_words_i),
        .wide_i      (wide_i),
        .word_bit0_i (start_addr_i[2]),
        .single_o    (chk_single),
        .mask_o      (chk_mask)
    );

    burst_addr_calc #(.WW(WW)) u_calc (
        .order_i      (st_q.order),
        .start_word_i (st_q.start_word),
        .total_i      (total_next),
        .mask_i       (st_q.mask),
        .word_o       (calc_word)
    );

    always_comb begin
        unit       = st_q.wide ? WW'(2) : WW'(1);
        total_next = st_q.total + unit;
        st_d       = st_q;
        if (start_i) begin
            st_d.start_word = start_addr_i[AW-1:2];
            st_d.order      = order_i;
            st_d.mask       = chk_mask;
            st_d.wide       = wide_i;
            st_d.single     = chk_single;
            st_d.total      = '0;
            st_d.word       = start_addr_i[AW-1:2];
        end else if (phase_done_i && !st_q.single) begin
            st_d.total = total_next;
            st_d.word  = calc_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o   = {st_q.word, 2'b00};
    assign single_o = st_q.single;

    logic pv_q;
    always_ff @(posedge clk) begin
        if (!rst_n) pv_q <= 1'b0;
        else        pv_q <= 1'b1;
    end

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(start_i) |-> addr_o[AW-1:2] == $past(start_addr_i[AW-1:2]));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && !$past(start_i) && !$past(phase_done_i) |-> $stable(addr_o));

    a_r11_single_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && !$past(start_i) && $past(single_o) |-> $stable(addr_o));

    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && !$past(start_i) && $past(phase_done_i) && !$past(single_o)
        && st_q.order == ORD_LINEAR
        |-> addr_o == $past(addr_o) + (st_q.wide ? AW'(8) : AW'(4)));

    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        pv_q && $past(start_i) && $past(order_i) == ORD_RSVD |-> single_o);
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] start_addr_i;
    logic [1:0]  order_i;
    logic [7:0]  line_words_i;
    logic        wide_i;
    logic        phase_done_i;
    logic [31:0] addr_o;
    logic        single_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    logic [29:0] m_start;
    logic [1:0]  m_order;
    int          m_line;
    logic        m_wide;
    logic        m_single;
    logic [29:0] m_total;

    always #4 clk = ~clk;

    burst_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .order_i(order_i), .line_words_i(line_words_i), .wide_i(wide_i),
        .phase_done_i(phase_done_i), .addr_o(addr_o), .single_o(single_o)
    );

    function automatic bit line_legal(int l);
        return (l == 4) || (l == 8) || (l == 16) || (l == 32);
    endfunction

    function automatic bit exp_single(logic [1:0] o, int l, logic w, logic [31:0] a);
        if (o == 2'b11) return 1'b1;
        if ((o == 2'b01 || o == 2'b10) && !line_legal(l)) return 1'b1;
        if (w && a[2]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_addr(logic [1:0] o, logic [29:0] s,
                                             logic [29:0] t, int l);
        logic [29:0] w;
        logic [29:0] m;
        m = 30'(l) - 30'd1;
        case (o)
            2'b01:   w = s ^ t;
            2'b10:   w = ((s & ~m) + (t & ~m)) | (((s & m) + (t & m)) & m);
            default: w = s + t;
        endcase
        return {w, 2'b00};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model, check at next negedge
    task automatic cycle(bit st, logic [31:0] a, logic [1:0] o, int l, logic w, bit pd,
                         string req);
        start_i      = st;
        start_addr_i = a;
        order_i      = o;
        line_words_i = 8'(l);
        wide_i       = w;
        phase_done_i = pd;
        @(posedge clk);
        if (st) begin
            m_start  = a[31:2];
            m_order  = o;
            m_line   = l;
            m_wide   = w;
            m_single = exp_single(o, l, w, a);
            m_total  = '0;
        end else if (pd && !m_single) begin
            m_total = m_total + (m_wide ? 30'd2 : 30'd1);
        end
        @(negedge clk);
        check(req, addr_o,
              m_single ? {m_start, 2'b00} : exp_addr(m_order, m_start, m_total, m_line));
        check(req, {31'd0, single_o}, {31'd0, m_single});
    endtask

    task automatic run_burst(logic [31:0] a, logic [1:0] o, int l, logic w, int n,
                             string req);
        cycle(1, a, o, l, w, 0, req);
        for (int i = 0; i < n; i++) cycle(0, 32'hdead_beef, 2'b11, 0, 0, 1, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; start_i = 0; start_addr_i = '0; order_i = 0;
        line_words_i = 0; wide_i = 0; phase_done_i = 0;
        m_start = '0; m_order = 0; m_line = 0; m_wide = 0; m_single = 0; m_total = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", addr_o, 32'h0);
        check("R1", {31'd0, single_o}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        check("R1", addr_o, 32'h0);
        check("R1", {31'd0, single_o}, 32'h0);

        // directed wrap L=4 from 0x108: 108,10C,100,104,118
        cycle(1, 32'h0000_0109, 2'b10, 4, 0, 0, "R2");
        check("R2", addr_o, 32'h108);
        cycle(0, 0, 0, 0, 0, 1, "R6"); check("R6", addr_o, 32'h10C);
        cycle(0, 0, 0, 0, 0, 1, "R6"); check("R6", addr_o, 32'h100);
        cycle(0, 0, 0, 0, 0, 1, "R6"); check("R6", addr_o, 32'h104);
        cycle(0, 0, 0, 0, 0, 1, "R7"); check("R7", addr_o, 32'h118);
        cycle(0, 0, 0, 0, 0, 0, "R3"); check("R3", addr_o, 32'h118);

        // toggle start word 0x43: 43,42,41,40,47
        cycle(1, 32'h0000_010C, 2'b01, 8, 0, 0, "R5");
        cycle(0, 0, 0, 0, 0, 1, "R5"); check("R5", addr_o, 32'h108);
        cycle(0, 0, 0, 0, 0, 1, "R5"); check("R5", addr_o, 32'h104);
        cycle(0, 0, 0, 0, 0, 1, "R5"); check("R5", addr_o, 32'h100);
        cycle(0, 0, 0, 0, 0, 1, "R5"); check("R5", addr_o, 32'h11C);

        // linear 64-bit
        cycle(1, 32'h0000_0200, 2'b00, 0, 1, 0, "R4");
        cycle(0, 0, 0, 0, 0, 1, "R4"); check("R4", addr_o, 32'h208);
        cycle(0, 0, 0, 0, 0, 1, "R9"); check("R9", {31'd0, single_o}, 32'h0);

        // reserved order, bad line, misaligned wide
        run_burst(32'h40, 2'b11, 8, 0, 3, "R8");  check("R8", {31'd0, single_o}, 32'h1);
        check("R11", addr_o, 32'h40);
        run_burst(32'h80, 2'b10, 0, 0, 2, "R9");  check("R9", {31'd0, single_o}, 32'h1);
        run_burst(32'h80, 2'b01, 12, 0, 2, "R9"); check("R9", {31'd0, single_o}, 32'h1);
        run_burst(32'h84, 2'b00, 12, 0, 2, "R9"); check("R9", addr_o, 32'h8C);
        run_burst(32'hC4, 2'b10, 8, 1, 2, "R10"); check("R10", {31'd0, single_o}, 32'h1);
        check("R11", addr_o, 32'hC4);

        // start collides with strobe
        cycle(1, 32'h300, 2'b00, 0, 0, 1, "R12"); check("R12", addr_o, 32'h300);
        cycle(0, 0, 0, 0, 0, 1, "R12");           check("R12", addr_o, 32'h304);

        // full wrap runs over two lines, every legal size and width
        for (int s = 2; s <= 5; s++) begin
            run_burst(32'h1000 + 32'((1 << s) - 2) * 4, 2'b10, 1 << s, 0, (2 << s) + 1, "R7");
            run_burst(32'h2000 + 32'((1 << s) - 2) * 4, 2'b10, 1 << s, 1, (1 << s) + 1, "R7");
        end

        // constrained random
        for (int b = 0; b < 300; b++) begin
            logic [31:0] a;
            logic [1:0]  o;
            int          l;
            logic        w;
            int          n;
            a = $urandom;
            o = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 5))
                0: l = 4; 1: l = 8; 2: l = 16; 3: l = 32;
                4: l = 0; default: l = $urandom_range(1, 255);
            endcase
            w = 1'($urandom_range(0, 1));
            if (w && $urandom_range(0, 3) != 0) a[2] = 1'b0;
            cycle(1, a, o, l, w, 1'($urandom_range(0, 1)), "R12");
            n = $urandom_range(0, 40);
            for (int i = 0; i < n; i++)
                cycle(0, $urandom, 2'($urandom), 0, 0, $urandom_range(0, 9) < 6,
                      o == 2'b01 ? "R5" : (o == 2'b10 ? "R6" : "R4"));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule